// File: doc/BRIEF.md
# Coin Vending Controller with Paced Change

This block runs a small candy vending machine. Five one-hot switches choose a product. Single-cycle pulses report each inserted nickel, dime or quarter. The block keeps a running coin credit and shows both the credit and the chosen price as two BCD digits. Seven-segment drive, debouncing and coin sensing are handled elsewhere.

When the credit covers the price of a validly selected product, the block does four things in order:

- It locks out further coins.
- It lights the dispense indicator for that product.
- It returns change as separate dime and nickel solenoid pulses, at one pulse per slow pacing tick.
- It clears the credit and reopens for coins.

The pacing tick comes from dividing the system clock. The division ratio is set by parameters, so a simulation can use a short period.

Top module: `coin_vend_ctrl`

## Requirements
- R1: After reset the credit reads 00, coin lock is low, all dispense indicators are low and both solenoid outputs are low.
- R2: With exactly one switch set, switch bit i selects a price of 55 + 5*i cents. `price_bcd_o` shows it as BCD, with tens in bits [7:4] and units in bits [3:0]. With no switch set, or more than one, it shows 00.
- R3: While unlocked, a nickel, dime or quarter pulse adds 5, 10 or 25 cents to the credit. Coins pulsed in the same cycle add together. `credit_bcd_o` (BCD, same digit layout as the price) shows the new value in the cycle after the pulse.
- R4: Any coin cycle that would raise the credit above 95 cents is ignored entirely, and the credit keeps its value.
- R5: With no switch set, or more than one, nothing is dispensed, coin lock stays low, and credit keeps accumulating.
- R6: Coin lock goes high in the same cycle that a valid selection's price is covered by the credit, and it stays high until the sequence ends. Coin pulses seen while it is high leave the credit unchanged.
- R7: From the cycle after the price is covered until payout finishes, exactly the dispense bit of the product chosen at that moment is high. Changing the switches afterwards does not change the product or the change owed.
- R8: The change equals credit minus price. It is paid with as many dime pulses as possible, followed by at most one nickel pulse, and no nickel ever comes before a dime.
- R9: Each solenoid pulse lasts one cycle. The two solenoids never pulse in the same cycle. Consecutive change pulses are exactly one pacing period apart (CLK_HZ/TICK_HZ cycles).
- R10: When payout ends, the dispense bit drops. One cycle later the credit reads 00 and coin lock is low.
- R11: An exact payment produces a dispense and no solenoid pulse at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_sw_i | input | 5 | Product select switches, one-hot |
| nickel_i | input | 1 | One-cycle pulse per nickel inserted |
| dime_i | input | 1 | One-cycle pulse per dime inserted |
| quarter_i | input | 1 | One-cycle pulse per quarter inserted |
| price_bcd_o | output | 8 | Price of the selected product, two BCD digits |
| credit_bcd_o | output | 8 | Accumulated credit, two BCD digits |
| vend_led_o | output | 5 | Dispense indicator per product |
| coin_lock_o | output | 1 | High while coins are refused |
| nickel_sol_o | output | 1 | Nickel change solenoid pulse |
| dime_sol_o | output | 1 | Dime change solenoid pulse |

## Verification
The bench first builds a 95-cent credit with no product chosen and then selects the 55-cent product. This forces the largest possible change, four dimes. A design that limited the change register, or paid nickels first, would show the wrong pulse counts or the wrong order.

Overflow is probed by offering a quarter at 75 cents and a nickel at 95 cents. A design without the limit would wrap or show a non-decimal credit.

Coins are inserted after the lock rises, and the switches are moved during payout. A design that kept accepting coins, or that re-read the live selection, would change the credit, the lit indicator or the pulse count.

Pulse spacing and the exact-payment case catch designs that pulse every cycle, or that emit a spurious zero-value pulse.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;

  localparam int unsigned NUM_PROD    = 5;
  localparam int unsigned IDX_W       = $clog2(NUM_PROD);
  localparam int unsigned CENT_W      = 7;
  localparam int unsigned BASE_CENTS  = 55;
  localparam int unsigned STEP_CENTS  = 5;
  localparam int unsigned MAX_CREDIT  = 95;
  localparam int unsigned NICKEL_C    = 5;
  localparam int unsigned DIME_C      = 10;
  localparam int unsigned QUARTER_C   = 25;

  typedef logic [CENT_W-1:0] cents_t;
  typedef logic [IDX_W-1:0]  prod_idx_t;

  typedef enum logic [1:0] {
    ST_ACCEPT   = 2'd0,
    ST_DISPENSE = 2'd1,
    ST_PAYOUT   = 2'd2,
    ST_DONE     = 2'd3
  } vend_state_t;

  // Price of product slot idx in cents.
  function automatic cents_t price_of(input int unsigned idx);
    return cents_t'(BASE_CENTS + STEP_CENTS * idx);
  endfunction

  // Binary cents (0..99) to two packed BCD digits.
  function automatic logic [7:0] cents_to_bcd(input cents_t c);
    int unsigned v;
    v = int'(c);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  // Value of the coins pulsed in one cycle.
  function automatic logic [CENT_W:0] coin_value(input logic n, input logic d,
                                                 input logic q);
    int unsigned s;
    s = (n ? NICKEL_C : 0) + (d ? DIME_C : 0) + (q ? QUARTER_C : 0);
    return (CENT_W+1)'(s);
  endfunction

endpackage

// File: rtl/vend_tick_div.sv
module vend_tick_div #(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned TICK_HZ = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned RATIO = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;
  localparam int unsigned CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/vend_price_sel.sv
module vend_price_sel
  import coin_vend_pkg::*;
(
  input  logic [NUM_PROD-1:0] sel_sw_i,
  output logic                valid_o,
  output prod_idx_t           idx_o,
  output cents_t              price_o
);
  cents_t table_w [NUM_PROD];

  for (genvar g = 0; g < NUM_PROD; g++) begin : g_price
    assign table_w[g] = price_of(g);
  end

  assign valid_o = $onehot(sel_sw_i);

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_PROD; i++) begin
      if (sel_sw_i[i]) idx_o = idx_o | prod_idx_t'(i);
    end
  end

  assign price_o = valid_o ? table_w[idx_o] : '0;
endmodule

// File: rtl/vend_credit_acc.sv
module vend_credit_acc
  import coin_vend_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   nickel_i,
  input  logic   dime_i,
  input  logic   quarter_i,
  input  logic   lock_i,
  input  logic   clear_i,
  output cents_t credit_o
);
  cents_t          credit_q;
  logic [CENT_W:0] sum_w;
  logic            any_coin_w;
  logic            accept_w;

  assign any_coin_w = nickel_i | dime_i | quarter_i;
  assign sum_w      = {1'b0, credit_q} + coin_value(nickel_i, dime_i, quarter_i);
  assign accept_w   = !lock_i && any_coin_w && (sum_w <= (CENT_W+1)'(MAX_CREDIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       credit_q <= '0;
    else if (clear_i)  credit_q <= '0;
    else if (accept_w) credit_q <= sum_w[CENT_W-1:0];
  end

  assign credit_o = credit_q;
endmodule

// File: rtl/vend_seq.sv
module vend_seq
  import coin_vend_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                sel_valid_i,
  input  prod_idx_t           sel_idx_i,
  input  cents_t              price_i,
  input  cents_t              credit_i,
  output vend_state_t         state_o,
  output logic                lock_o,
  output logic                clear_o,
  output logic [NUM_PROD-1:0] vend_led_o,
  output logic                nickel_sol_o,
  output logic                dime_sol_o
);
  vend_state_t state_q;
  prod_idx_t   prod_q;
  cents_t      change_q;
  logic        nickel_q, dime_q;
  logic        reach_w;
  logic        showing_w;

  assign reach_w   = (state_q == ST_ACCEPT) && sel_valid_i && (credit_i >= price_i);
  assign lock_o    = (state_q != ST_ACCEPT) || reach_w;
  assign clear_o   = (state_q == ST_DONE);
  assign showing_w = (state_q == ST_DISPENSE) || (state_q == ST_PAYOUT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_ACCEPT;
      prod_q   <= '0;
      change_q <= '0;
      nickel_q <= 1'b0;
      dime_q   <= 1'b0;
    end else begin
      nickel_q <= 1'b0;
      dime_q   <= 1'b0;
      unique case (state_q)
        ST_ACCEPT: if (reach_w) begin
          state_q  <= ST_DISPENSE;
          prod_q   <= sel_idx_i;
          change_q <= credit_i - price_i;
        end
        ST_DISPENSE: if (tick_i) state_q <= ST_PAYOUT;
        ST_PAYOUT: if (tick_i) begin
          if (change_q >= cents_t'(DIME_C)) begin
            dime_q   <= 1'b1;
            change_q <= change_q - cents_t'(DIME_C);
          end else if (change_q >= cents_t'(NICKEL_C)) begin
            nickel_q <= 1'b1;
            change_q <= change_q - cents_t'(NICKEL_C);
          end else begin
            state_q  <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_ACCEPT;
        default: state_q <= ST_ACCEPT;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_PROD; g++) begin : g_led
    assign vend_led_o[g] = showing_w && (prod_q == prod_idx_t'(g));
  end

  assign state_o      = state_q;
  assign nickel_sol_o = nickel_q;
  assign dime_sol_o   = dime_q;
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import coin_vend_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 50_000_000,
  parameter int unsigned TICK_HZ = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PROD-1:0] sel_sw_i,
  input  logic                nickel_i,
  input  logic                dime_i,
  input  logic                quarter_i,
  output logic [7:0]          price_bcd_o,
  output logic [7:0]          credit_bcd_o,
  output logic [NUM_PROD-1:0] vend_led_o,
  output logic                coin_lock_o,
  output logic                nickel_sol_o,
  output logic                dime_sol_o
);
  logic        tick_w;
  logic        sel_valid_w;
  prod_idx_t   sel_idx_w;
  cents_t      price_w;
  cents_t      credit_q;
  logic        clear_w;
  logic        pay_w;
  vend_state_t state_w;

  vend_tick_div #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick_w)
  );

  vend_price_sel u_price (
    .sel_sw_i(sel_sw_i), .valid_o(sel_valid_w), .idx_o(sel_idx_w), .price_o(price_w)
  );

  vend_credit_acc u_credit (
    .clk_i(clk_i), .rst_ni(rst_ni), .nickel_i(nickel_i), .dime_i(dime_i),
    .quarter_i(quarter_i), .lock_i(coin_lock_o), .clear_i(clear_w), .credit_o(credit_q)
  );

  vend_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_w), .sel_valid_i(sel_valid_w),
    .sel_idx_i(sel_idx_w), .price_i(price_w), .credit_i(credit_q), .state_o(state_w),
    .lock_o(coin_lock_o), .clear_o(clear_w), .vend_led_o(vend_led_o),
    .nickel_sol_o(nickel_sol_o), .dime_sol_o(dime_sol_o)
  );

  assign pay_w        = (state_w == ST_PAYOUT);
  assign price_bcd_o  = cents_to_bcd(price_w);
  assign credit_bcd_o = cents_to_bcd(credit_q);
endmodule

// File: rtl/coin_vend_chk.sv
module coin_vend_chk
  import coin_vend_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                nickel_i,
  input logic                dime_i,
  input logic                quarter_i,
  input logic [NUM_PROD-1:0] vend_led_o,
  input logic                coin_lock_o,
  input logic                nickel_sol_o,
  input logic                dime_sol_o,
  input cents_t              credit_q,
  input logic                clear_w,
  input logic                pay_w
);
  logic any_coin;
  assign any_coin = nickel_i | dime_i | quarter_i;

  p_credit_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    credit_q <= cents_t'(MAX_CREDIT));

  p_no_coin_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_coin && !clear_w) |=> $stable(credit_q));

  p_locked_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coin_lock_o && !clear_w) |=> $stable(credit_q));

  p_led_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(vend_led_o));

  p_led_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|vend_led_o) |-> coin_lock_o);

  p_sol_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nickel_sol_o && dime_sol_o));

  p_dime_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dime_sol_o |=> !dime_sol_o);

  p_nickel_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nickel_sol_o |=> !nickel_sol_o);

  p_sol_in_payout_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nickel_sol_o || dime_sol_o) |-> pay_w);

  p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_w |=> (credit_q == '0 && !coin_lock_o));
endmodule

bind coin_vend_ctrl coin_vend_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .nickel_i(nickel_i), .dime_i(dime_i),
  .quarter_i(quarter_i), .vend_led_o(vend_led_o), .coin_lock_o(coin_lock_o),
  .nickel_sol_o(nickel_sol_o), .dime_sol_o(dime_sol_o), .credit_q(credit_q),
  .clear_w(clear_w), .pay_w(pay_w)
);

// File: tb/coin_vend_ctrl_tb_top.sv
module coin_vend_ctrl_tb_top;
  localparam int RATIO = 8;
  localparam int WD_LIMIT = 150000;
  localparam int NK = 1, DM = 2, QT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] sel = '0;
  logic nk = 1'b0, dm = 1'b0, qt = 1'b0;
  logic [7:0] price_bcd, credit_bcd;
  logic [4:0] led;
  logic lock, nsol, dsol;

  always #5 clk = ~clk;

  coin_vend_ctrl #(.CLK_HZ(RATIO), .TICK_HZ(1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_sw_i(sel), .nickel_i(nk), .dime_i(dm),
    .quarter_i(qt), .price_bcd_o(price_bcd), .credit_bcd_o(credit_bcd),
    .vend_led_o(led), .coin_lock_o(lock), .nickel_sol_o(nsol), .dime_sol_o(dsol)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  function automatic int bcd(input int c);
    return ((c / 10) << 4) | (c % 10);
  endfunction

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  // Solenoid monitor
  bit mon_on = 0;
  int dimes = 0, nickels = 0, last_pulse = -1, order_bad = 0, both_bad = 0;
  always @(negedge clk) begin
    if (mon_on && (dsol || nsol)) begin
      if (dsol && nsol) both_bad++;
      if (dsol && nickels > 0) order_bad++;
      if (dsol) dimes++;
      if (nsol) nickels++;
      if (last_pulse >= 0) check("R9", cyc - last_pulse, RATIO, "pulse spacing");
      last_pulse = cyc;
    end
  end

  task automatic do_reset();
    sel = '0; nk = 0; dm = 0; qt = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic put_coin(input int kind);
    @(negedge clk);
    nk = (kind == NK); dm = (kind == DM); qt = (kind == QT);
    @(negedge clk);
    nk = 0; dm = 0; qt = 0;
  endtask

  function automatic int coin_cents(input int kind);
    return (kind == NK) ? 5 : (kind == DM) ? 10 : (kind == QT) ? 25 : 0;
  endfunction

  task automatic t_reset_state();
    do_reset();
    check("R1", credit_bcd, 0, "credit after reset");
    check("R1", lock, 0, "lock after reset");
    check("R1", led, 0, "leds after reset");
    check("R1", nsol | dsol, 0, "solenoids after reset");
  endtask

  task automatic t_prices();
    for (int i = 0; i < 5; i++) begin
      sel = 5'(1 << i); #1;
      check("R2", price_bcd, bcd(55 + 5 * i), "price of one switch");
    end
    sel = '0; #1;
    check("R2", price_bcd, 0, "price with no switch");
    sel = 5'b10010; #1;
    check("R2", price_bcd, 0, "price with two switches");
    sel = '0;
  endtask

  task automatic t_accumulate();
    do_reset();
    put_coin(NK); check("R3", credit_bcd, bcd(5), "credit after nickel");
    put_coin(DM); check("R3", credit_bcd, bcd(15), "credit after dime");
    put_coin(QT); check("R3", credit_bcd, bcd(40), "credit after quarter");
    @(negedge clk); nk = 1; dm = 1; @(negedge clk); nk = 0; dm = 0;
    check("R3", credit_bcd, bcd(55), "credit after nickel+dime same cycle");
    sel = 5'b00101;
    put_coin(DM);
    repeat (3) @(negedge clk);
    check("R5", credit_bcd, bcd(65), "credit grows with two switches");
    check("R5", lock, 0, "no lock with two switches");
    check("R5", led, 0, "no dispense with two switches");
    sel = '0;
  endtask

  task automatic t_overflow();
    do_reset();
    repeat (3) put_coin(QT);
    put_coin(QT); check("R4", credit_bcd, bcd(75), "quarter at 75 ignored");
    put_coin(DM); put_coin(DM);
    check("R4", credit_bcd, bcd(95), "credit reaches 95");
    put_coin(NK); check("R4", credit_bcd, bcd(95), "nickel at 95 ignored");
    check("R5", lock, 0, "no lock without selection");
  endtask

  task automatic vend_run(input string tag, input int idx, input bit late,
                          input int c0, input int c1, input int c2, input int c3, input int c4);
    int coins[5];
    int sum, change, wait_n, led_bad;
    coins = '{c0, c1, c2, c3, c4};
    do_reset();
    sum = 0;
    sel = late ? 5'b0 : 5'(1 << idx);
    foreach (coins[k]) if (coins[k] != 0) begin
      put_coin(coins[k]);
      sum += coin_cents(coins[k]);
    end
    if (late) begin sel = 5'(1 << idx); #1; end
    change = sum - (55 + 5 * idx);
    dimes = 0; nickels = 0; last_pulse = -1; order_bad = 0; both_bad = 0; mon_on = 1;
    check("R6", lock, 1, {tag, " lock when price covered"});
    check("R3", credit_bcd, bcd(sum), {tag, " credit at lock"});
    put_coin(NK);
    check("R6", credit_bcd, bcd(sum), {tag, " coin while locked ignored"});
    check("R7", led, 1 << idx, {tag, " dispense indicator"});
    sel = 5'(1 << ((idx + 2) % 5));
    led_bad = 0; wait_n = 0;
    while (led != 0 && wait_n < 20 * RATIO) begin
      if (led != (1 << idx)) led_bad++;
      @(negedge clk); wait_n++;
    end
    mon_on = 0;
    check("R7", led_bad, 0, {tag, " indicator held after switch change"});
    check("R10", led, 0, {tag, " indicator drops at end"});
    check("R8", dimes, change / 10, {tag, " dime pulses"});
    check("R8", nickels, (change % 10) / 5, {tag, " nickel pulses"});
    check("R8", order_bad, 0, {tag, " dimes before nickel"});
    check("R9", both_bad, 0, {tag, " solenoids exclusive"});
    if (change == 0) check("R11", dimes + nickels, 0, {tag, " exact pay no pulses"});
    @(negedge clk);
    check("R10", credit_bcd, 0, {tag, " credit cleared"});
    check("R10", lock, 0, {tag, " lock released"});
    sel = '0;
  endtask

  initial begin
    t_reset_state();
    t_prices();
    t_accumulate();
    t_overflow();
    vend_run("p0 75", 0, 0, QT, QT, QT, 0, 0);
    vend_run("p1 exact", 1, 0, QT, QT, DM, 0, 0);
    vend_run("p1 15", 1, 0, QT, QT, QT, 0, 0);
    vend_run("p3 5", 3, 0, QT, QT, QT, 0, 0);
    vend_run("p2 10", 2, 0, QT, QT, QT, 0, 0);
    vend_run("p4 exact", 4, 0, QT, QT, QT, 0, 0);
    vend_run("p0 max 40", 0, 1, QT, QT, QT, DM, DM);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule